// File: doc/BRIEF.md
# Multicycle RISC Datapath

This block is the storage-and-steering half of a 32-bit processor that runs each instruction over several clock cycles. A single ALU and a single memory port are reused from one step to the next, and the intermediate results travel between steps through holding registers: the instruction register, the memory data register, the two operand latches and the ALU result latch. An external sequencer drives a set of control pins every cycle. In return it receives the instruction opcode and the ALU zero flag, which tell it what to do next.

Inside the block are the program counter and its three-way next-value selection, which can be made conditional on the zero flag. The block also holds the memory address multiplexer, the two ALU operand multiplexers, immediate sign extension, jump-target formation, a 32-entry register file with a hard-wired zero register, and a small decoder. That decoder turns the two-bit ALU mode plus the instruction function field into an ALU operation. Memory sits outside the block, and its read and write strobes go straight from the sequencer to memory.

Top module: `mc_datapath`

## Requirements
- R1: When `rst_n` is sampled low at a rising clock edge, the program counter becomes 0 at that edge, so `mem_addr` reads 0 while `ctl_addr_sel` is 0.
- R2: The instruction register takes `mem_rdata` at a clock edge only when `ctl_ir_wr` is 1 and holds otherwise. `opcode` always shows instruction bits [31:26].
- R3: `mem_addr` is the program counter when `ctl_addr_sel` is 0, and the ALU result latch when it is 1.
- R4: The first ALU operand is the program counter when `ctl_srca` is 0, and the A latch when it is 1. The second operand depends on `ctl_srcb`: 0 selects the B latch, 1 selects the constant 4, 2 selects sign-extended instruction bits [15:0], and 3 selects that value shifted left by two.
- R5: `ctl_alu_op` 0 adds and 1 subtracts. When it is 2, the function field (instruction bits [5:0]) chooses the operation: 32 add, 34 subtract, 36 AND, 37 OR, 42 signed set-on-less-than giving 1 or 0. `alu_zero` is 1 exactly when the 32-bit ALU result is 0.
- R6: The program counter is written at a clock edge when `ctl_pc_wr` is 1, or when `ctl_pc_wr_cond` is 1 and `alu_zero` is 1. Otherwise it keeps its value.
- R7: The new program counter value depends on `ctl_pc_src`: 0 selects the live ALU result, 1 selects the ALU result latch, and 2 selects the jump target. The jump target is the old PC bits [31:28], then instruction bits [25:0], then two zero bits.
- R8: The register file reads the register named by instruction bits [25:21] into A and the one named by bits [20:16] into B. The write address is bits [20:16] when `ctl_dst_sel` is 0 and bits [15:11] when it is 1. The write data is the ALU result latch when `ctl_wb_sel` is 0 and the memory data register when it is 1. A write happens at the edge that ends a cycle with `ctl_reg_wr` at 1. Register 0 always reads 0, and writes to it are ignored.
- R9: The memory data register, A, B and the ALU result latch load new values at every clock edge. A value computed in one cycle is therefore available in exactly the next, and `mem_wdata` is the B latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| ctl_pc_wr | input | 1 | Unconditional program counter write |
| ctl_pc_wr_cond | input | 1 | Program counter write when the ALU result is zero |
| ctl_pc_src | input | 2 | Next program counter source select |
| ctl_addr_sel | input | 1 | Memory address select: 0 PC, 1 ALU result latch |
| ctl_ir_wr | input | 1 | Instruction register load enable |
| ctl_reg_wr | input | 1 | Register file write enable |
| ctl_dst_sel | input | 1 | Write register select: 0 bits [20:16], 1 bits [15:11] |
| ctl_wb_sel | input | 1 | Write data select: 0 ALU result latch, 1 memory data register |
| ctl_srca | input | 1 | First ALU operand select |
| ctl_srcb | input | 2 | Second ALU operand select |
| ctl_alu_op | input | 2 | ALU mode: add, subtract or function field |
| mem_rdata | input | 32 | Read data from the shared memory |
| mem_addr | output | 32 | Address to the shared memory |
| mem_wdata | output | 32 | Store data to memory (B latch) |
| alu_zero | output | 1 | ALU result equals zero |
| opcode | output | 6 | Instruction bits [31:26] for the sequencer |

## Verification
The embedded assertions watch several things on every cycle. They check the program counter's reset and hold conditions, and the branch and jump loads of the counter. They check that the instruction register holds whenever its enable is low, that a register read returns the data just written to it, and that set-on-less-than never yields more than one bit. Everything that depends on the actual values has to come from the bench's scenarios. The bench steps complete load, store, register-type, branch and jump sequences, the way a sequencer would. Those scenarios show the operand and address selection, each ALU function with its zero flag, the signed comparison, the sign-extended negative offset, the ignored writes to register 0, and the arithmetic of the taken and untaken branch targets.

// File: rtl/mc_pkg.sv
// Shared types and encodings for the multicycle datapath.
// Assumes a 32-bit instruction word with fixed field positions.
package mc_pkg;
    localparam int REG_AW = 5;

    typedef enum logic [2:0] {
        ALU_ADD = 3'd0,
        ALU_SUB = 3'd1,
        ALU_AND = 3'd2,
        ALU_OR  = 3'd3,
        ALU_SLT = 3'd4
    } alu_fn_e;

    // function field codes used when the ALU mode defers to the instruction
    localparam logic [5:0] FC_ADD = 6'd32;
    localparam logic [5:0] FC_SUB = 6'd34;
    localparam logic [5:0] FC_AND = 6'd36;
    localparam logic [5:0] FC_OR  = 6'd37;
    localparam logic [5:0] FC_SLT = 6'd42;

    // ALU mode codes
    localparam logic [1:0] AM_ADD  = 2'd0;
    localparam logic [1:0] AM_SUB  = 2'd1;
    localparam logic [1:0] AM_FUNC = 2'd2;

    // next program counter sources
    localparam logic [1:0] PCS_ALU    = 2'd0;
    localparam logic [1:0] PCS_LATCH  = 2'd1;
    localparam logic [1:0] PCS_JUMP   = 2'd2;

    // second operand sources
    localparam logic [1:0] SB_REG   = 2'd0;
    localparam logic [1:0] SB_FOUR  = 2'd1;
    localparam logic [1:0] SB_IMM   = 2'd2;
    localparam logic [1:0] SB_IMMSH = 2'd3;
endpackage

// File: rtl/mc_alu_ctl.sv
// ALU operation decoder.
// Maps the two-bit ALU mode plus the function field to an operation.
// Assumes unknown function codes and the unused mode fall back to add.
module mc_alu_ctl
    import mc_pkg::*;
(
    input  logic [1:0] alu_mode,
    input  logic [5:0] func,
    output alu_fn_e    fn
);
    // Decode the operation for this cycle.
    always_comb begin
        fn = ALU_ADD;
        if (alu_mode == AM_SUB) begin
            fn = ALU_SUB;
        end else if (alu_mode == AM_FUNC) begin
            case (func)
                FC_SUB:  fn = ALU_SUB;
                FC_AND:  fn = ALU_AND;
                FC_OR:   fn = ALU_OR;
                FC_SLT:  fn = ALU_SLT;
                default: fn = ALU_ADD;
            endcase
        end
    end
endmodule

// File: rtl/mc_alu.sv
// Combinational ALU with zero detect.
// Assumes set-on-less-than compares as signed two's complement.
module mc_alu
    import mc_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_fn_e      fn,
    output logic [W-1:0] y,
    output logic         zero
);
    // Compute the selected operation.
    always_comb begin
        case (fn)
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
            default: y = a + b;
        endcase
    end

    assign zero = (y == '0);

    // R5: a comparison result is a single bit
    always_comb begin
        if (fn == ALU_SLT) begin
            p_slt_onebit_r5: assert (y[W-1:1] == '0);
        end
    end
endmodule

// File: rtl/mc_regfile.sv
// Register file: two combinational reads, one synchronous write.
// Assumes entry 0 is hard-wired to zero; writes to it are dropped.
module mc_regfile #(
    parameter int W  = 32,
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd,
    input  logic [AW-1:0] ra1,
    input  logic [AW-1:0] ra2,
    output logic [W-1:0]  rd1,
    output logic [W-1:0]  rd2
);
    localparam int DEPTH = 1 << AW;

    logic [W-1:0] regs [DEPTH];

    // Store write data at the end of the cycle, skipping entry 0.
    always_ff @(posedge clk) begin
        if (we && wa != '0) begin
            regs[wa] <= wd;
        end
    end

    assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
    assign rd2 = (ra2 == '0) ? '0 : regs[ra2];

    // R8: a written nonzero register reads back the written data
    p_rd_after_wr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (we && wa != '0) |=> (ra1 != $past(wa) || rd1 == $past(wd)));
endmodule

// File: rtl/mc_datapath.sv
// Multicycle datapath top.
// Holds the PC, instruction/data latches, register file and ALU, all steered
// by per-cycle control pins from an external sequencer.
// Assumes one shared memory port outside the block with combinational reads.
module mc_datapath
    import mc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ctl_pc_wr,
    input  logic            ctl_pc_wr_cond,
    input  logic [1:0]      ctl_pc_src,
    input  logic            ctl_addr_sel,
    input  logic            ctl_ir_wr,
    input  logic            ctl_reg_wr,
    input  logic            ctl_dst_sel,
    input  logic            ctl_wb_sel,
    input  logic            ctl_srca,
    input  logic [1:0]      ctl_srcb,
    input  logic [1:0]      ctl_alu_op,
    input  logic [XLEN-1:0] mem_rdata,
    output logic [XLEN-1:0] mem_addr,
    output logic [XLEN-1:0] mem_wdata,
    output logic            alu_zero,
    output logic [5:0]      opcode
);
    localparam int IMM_W  = 16;
    localparam int JMP_W  = 26;
    localparam int HI_W   = XLEN - JMP_W - 2;

    logic [XLEN-1:0] pc_q, ir_q, mdr_q, a_q, b_q, aout_q;
    logic [XLEN-1:0] rd1, rd2, opa, opb, alu_y, pc_next;
    logic [XLEN-1:0] imm_sx, imm_sh, jmp_tgt, wdata;
    logic [REG_AW-1:0] waddr;
    logic            pc_en;
    alu_fn_e         fn;

    // Program counter with synchronous reset and gated update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= '0;
        end else if (pc_en) begin
            pc_q <= pc_next;
        end
    end

    // Instruction register, loaded only when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ir_q <= '0;
        end else if (ctl_ir_wr) begin
            ir_q <= mem_rdata;
        end
    end

    // Step-to-step latches, reloaded on every edge.
    always_ff @(posedge clk) begin
        mdr_q  <= mem_rdata;
        a_q    <= rd1;
        b_q    <= rd2;
        aout_q <= alu_y;
    end

    assign imm_sx  = {{(XLEN-IMM_W){ir_q[IMM_W-1]}}, ir_q[IMM_W-1:0]};
    assign imm_sh  = {imm_sx[XLEN-3:0], 2'b00};
    assign jmp_tgt = {pc_q[XLEN-1 -: HI_W], ir_q[JMP_W-1:0], 2'b00};

    assign waddr = ctl_dst_sel ? ir_q[15:11] : ir_q[20:16];
    assign wdata = ctl_wb_sel ? mdr_q : aout_q;

    mc_regfile #(.W(XLEN), .AW(REG_AW)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ctl_reg_wr),
        .wa    (waddr),
        .wd    (wdata),
        .ra1   (ir_q[25:21]),
        .ra2   (ir_q[20:16]),
        .rd1   (rd1),
        .rd2   (rd2)
    );

    assign opa = ctl_srca ? a_q : pc_q;

    // Choose the second ALU operand.
    always_comb begin
        case (ctl_srcb)
            SB_REG:   opb = b_q;
            SB_FOUR:  opb = XLEN'(4);
            SB_IMM:   opb = imm_sx;
            default:  opb = imm_sh;
        endcase
    end

    mc_alu_ctl u_actl (
        .alu_mode (ctl_alu_op),
        .func     (ir_q[5:0]),
        .fn       (fn)
    );

    mc_alu #(.W(XLEN)) u_alu (
        .a    (opa),
        .b    (opb),
        .fn   (fn),
        .y    (alu_y),
        .zero (alu_zero)
    );

    // Choose the next program counter value.
    always_comb begin
        case (ctl_pc_src)
            PCS_LATCH: pc_next = aout_q;
            PCS_JUMP:  pc_next = jmp_tgt;
            default:   pc_next = alu_y;
        endcase
    end

    assign pc_en     = ctl_pc_wr | (ctl_pc_wr_cond & alu_zero);
    assign mem_addr  = ctl_addr_sel ? aout_q : pc_q;
    assign mem_wdata = b_q;
    assign opcode    = ir_q[31:26];

    // R1: reset drives the counter to zero
    p_pc_reset_r1: assert property (@(posedge clk)
        !rst_n |=> pc_q == '0);

    // R6: without a write request the counter holds
    p_pc_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_pc_wr && !(ctl_pc_wr_cond && alu_zero)) |=> pc_q == $past(pc_q));

    // R2: the instruction register holds without its enable
    p_ir_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_ir_wr |=> $stable(ir_q));

    // R7: a latched-target write copies the ALU result latch
    p_pc_latch_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_pc_wr && ctl_pc_src == PCS_LATCH) |=> pc_q == $past(aout_q));

    // R7: a jump keeps the top bits and lands word aligned
    p_pc_jump_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_pc_wr && ctl_pc_src == PCS_JUMP) |=>
        (pc_q[1:0] == 2'b00 && pc_q[XLEN-1 -: HI_W] == $past(pc_q[XLEN-1 -: HI_W])));
endmodule

// File: tb/tb_mc_datapath.sv
// Directed bench: acts as the sequencer and runs a short program.
module tb_mc_datapath;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pc_wr, pc_wr_cond, addr_sel, ir_wr, reg_wr, dst_sel, wb_sel, srca;
    logic [1:0]  pc_src, srcb, alu_op;
    logic [31:0] mem_rdata, mem_addr, mem_wdata;
    logic        alu_zero;
    logic [5:0]  opcode;

    logic [31:0] mem [64];
    logic [31:0] ref_rf [32];
    logic [31:0] exp_pc;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    assign mem_rdata = mem[mem_addr[7:2]];

    mc_datapath dut (
        .clk(clk), .rst_n(rst_n),
        .ctl_pc_wr(pc_wr), .ctl_pc_wr_cond(pc_wr_cond), .ctl_pc_src(pc_src),
        .ctl_addr_sel(addr_sel), .ctl_ir_wr(ir_wr), .ctl_reg_wr(reg_wr),
        .ctl_dst_sel(dst_sel), .ctl_wb_sel(wb_sel), .ctl_srca(srca),
        .ctl_srcb(srcb), .ctl_alu_op(alu_op),
        .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .alu_zero(alu_zero), .opcode(opcode)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic idle();
        {pc_wr, pc_wr_cond, addr_sel, ir_wr, reg_wr, dst_sel, wb_sel, srca} = '0;
        pc_src = 2'd0; srcb = 2'd0; alu_op = 2'd0;
        #1;
    endtask

    function automatic logic [31:0] sx(input logic [15:0] v);
        return {{16{v[15]}}, v};
    endfunction

    function automatic logic [31:0] enc_r(input int rs, rt, rd, input logic [5:0] fc);
        return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, fc};
    endfunction

    function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, rt, input logic [15:0] imm);
        return {op, 5'(rs), 5'(rt), imm};
    endfunction

    // Reference ALU written from R5.
    function automatic logic [31:0] ref_alu(input logic [5:0] fc, input logic [31:0] a, b);
        case (fc)
            6'd34: return a - b;
            6'd36: return a & b;
            6'd37: return a | b;
            6'd42: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
            default: return a + b;
        endcase
    endfunction

    function automatic void ref_write(input int r, input logic [31:0] v);
        if (r != 0) ref_rf[r] = v;
    endfunction

    // Fetch step: address from PC (R3), PC+4 via constant operand (R4, R7).
    task automatic do_fetch(input logic [5:0] exp_op);
        idle();
        ir_wr = 1; srcb = 2'd1; pc_wr = 1; #1;
        chk(mem_addr == exp_pc, "R3 fetch address", mem_addr, exp_pc);
        tick();
        idle();
        chk(opcode == exp_op, "R2 opcode loaded", {26'd0, opcode}, {26'd0, exp_op});
        exp_pc = exp_pc + 4;
        chk(mem_addr == exp_pc, "R7 pc plus four", mem_addr, exp_pc);
    endtask

    // Decode step: branch target into latch (R4 shifted immediate); IR holds.
    task automatic do_decode(input logic [5:0] exp_op);
        idle();
        srcb = 2'd3; #1;
        tick();
        idle();
        chk(opcode == exp_op, "R2 opcode held", {26'd0, opcode}, {26'd0, exp_op});
    endtask

    task automatic run_r(input int rs, rt, rd, input logic [5:0] fc);
        logic [31:0] res;
        res = ref_alu(fc, ref_rf[rs], ref_rf[rt]);
        do_fetch(6'd0);
        do_decode(6'd0);
        srca = 1; srcb = 2'd0; alu_op = 2'd2; #1;
        chk(alu_zero == (res == 0), "R5 zero flag on function op", {31'd0, alu_zero}, {31'd0, res == 0});
        tick();
        idle();
        reg_wr = 1; dst_sel = 1; #1;
        tick();
        idle();
        ref_write(rd, res);
    endtask

    task automatic run_lw(input int rs, rt, input logic [15:0] imm);
        logic [31:0] ea;
        ea = ref_rf[rs] + sx(imm);
        do_fetch(6'd35);
        do_decode(6'd35);
        srca = 1; srcb = 2'd2; #1;
        tick();
        idle();
        addr_sel = 1; #1;
        chk(mem_addr == ea, "R9 load address from latch", mem_addr, ea);
        tick();
        idle();
        reg_wr = 1; wb_sel = 1; #1;
        tick();
        idle();
        ref_write(rt, mem[ea[7:2]]);
    endtask

    task automatic run_sw(input int rs, rt, input logic [15:0] imm);
        logic [31:0] ea;
        ea = ref_rf[rs] + sx(imm);
        do_fetch(6'd43);
        do_decode(6'd43);
        srca = 1; srcb = 2'd2; #1;
        tick();
        idle();
        addr_sel = 1; #1;
        chk(mem_addr == ea, "R3 store address", mem_addr, ea);
        chk(mem_wdata == ref_rf[rt], "R8 store data from B", mem_wdata, ref_rf[rt]);
        mem[mem_addr[7:2]] = mem_wdata;
        tick();
        idle();
    endtask

    task automatic run_beq(input int rs, rt, input logic [15:0] imm);
        bit taken;
        logic [31:0] tgt;
        taken = (ref_rf[rs] == ref_rf[rt]);
        tgt = exp_pc + 4 + {sx(imm)[29:0], 2'b00};
        do_fetch(6'd4);
        do_decode(6'd4);
        srca = 1; alu_op = 2'd1; pc_wr_cond = 1; pc_src = 2'd1; #1;
        chk(alu_zero == taken, "R5 subtract zero flag", {31'd0, alu_zero}, {31'd0, taken});
        tick();
        idle();
        if (taken) exp_pc = tgt;
        chk(mem_addr == exp_pc, "R6 conditional pc write", mem_addr, exp_pc);
    endtask

    task automatic run_j(input logic [25:0] tgt);
        do_fetch(6'd2);
        do_decode(6'd2);
        pc_wr = 1; pc_src = 2'd2; #1;
        tick();
        idle();
        exp_pc = {exp_pc[31:28], tgt, 2'b00};
        chk(mem_addr == exp_pc, "R7 jump target", mem_addr, exp_pc);
    endtask

    task automatic do_reset();
        idle();
        rst_n = 0;
        tick();
        tick();
        chk(mem_addr == 32'd0, "R1 pc cleared by reset", mem_addr, 32'd0);
        rst_n = 1;
        exp_pc = 32'd0;
    endtask

    task automatic load_program();
        for (int i = 0; i < 64; i++) mem[i] = 32'd0;
        for (int i = 0; i < 32; i++) ref_rf[i] = 32'd0;
        mem[0]  = enc_i(6'd35, 0, 1, 16'h0080);
        mem[1]  = enc_i(6'd35, 0, 2, 16'h0084);
        mem[2]  = enc_r(1, 2, 3, 6'd32);
        mem[3]  = enc_r(1, 2, 4, 6'd34);
        mem[4]  = enc_r(1, 2, 5, 6'd36);
        mem[5]  = enc_r(1, 2, 6, 6'd37);
        mem[6]  = enc_r(2, 1, 7, 6'd42);
        mem[7]  = enc_r(1, 1, 9, 6'd34);
        mem[8]  = enc_r(1, 1, 0, 6'd32);
        mem[9]  = enc_i(6'd4, 1, 2, 16'd5);
        mem[10] = enc_i(6'd4, 3, 3, 16'd2);
        mem[13] = {6'd2, 26'd24};
        mem[24] = enc_i(6'd43, 0, 0, 16'h008C);
        mem[25] = enc_i(6'd43, 0, 3, 16'h0088);
        mem[26] = enc_i(6'd35, 0, 8, 16'h00A0);
        mem[27] = enc_i(6'd43, 8, 6, 16'hFFFC);
        mem[28] = enc_i(6'd43, 0, 7, 16'h0090);
        mem[32] = 32'd5;
        mem[33] = 32'hFFFF_FFFD;
        mem[35] = 32'hDEAD_BEEF;
        mem[40] = 32'h0000_00C0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        load_program();
        do_reset();
        // R9, R8: loads through MDR into rt
        run_lw(0, 1, 16'h0080);
        run_lw(0, 2, 16'h0084);
        // R5: each function code
        run_r(1, 2, 3, 6'd32);
        run_r(1, 2, 4, 6'd34);
        run_r(1, 2, 5, 6'd36);
        run_r(1, 2, 6, 6'd37);
        run_r(2, 1, 7, 6'd42);
        run_r(1, 1, 9, 6'd34);
        // R8: write to register 0 is dropped
        run_r(1, 1, 0, 6'd32);
        // R6: untaken then taken branch
        run_beq(1, 2, 16'd5);
        run_beq(3, 3, 16'd2);
        // R7: jump
        run_j(26'd24);
        run_sw(0, 0, 16'h008C);
        run_sw(0, 3, 16'h0088);
        run_lw(0, 8, 16'h00A0);
        // R4: negative sign-extended offset
        run_sw(8, 6, 16'hFFFC);
        run_sw(7 - 7, 7, 16'h0090);
        chk(mem[34] == 32'd2, "R5 add result stored", mem[34], 32'd2);
        chk(mem[35] == 32'd0, "R8 register 0 reads zero", mem[35], 32'd0);
        chk(mem[36] == 32'd1, "R5 signed less-than", mem[36], 32'd1);
        chk(mem[47] == 32'hFFFF_FFFD, "R4 negative offset store", mem[47], 32'hFFFF_FFFD);
        // R1: reset in mid-run
        do_reset();
        finish_run();
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end
endmodule